// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block lets a clocked host read and write an external 8192 x 8 asynchronous static RAM. The RAM has a shared bidirectional data bus, two chip selects of opposite polarity (an active-low one and an active-high one), an active-low output enable and an active-low write enable. The RAM is selected only while both chip selects are active together. A write happens only while write enable is low and the RAM is selected. The write window closes as soon as any one of those three strobes deasserts.

The host issues one access at a time. It raises `host_req` for a cycle with an address, a write flag and write data. `host_busy` stays high until the sequencer is idle again. `host_ready` pulses when the access completes, and for a read it comes with the captured byte on `host_rdata`. On the memory side the sequencer presents the address first with all strobes inactive. It then opens a read window (select plus output enable) or a write window (select plus write enable, with the data driven). After a write it keeps the select and the data for a hold interval. After a read it keeps the data bus undriven for a turnaround interval. Every interval is a parameter in clock cycles, rounded up from the memory's nanosecond figures.

Output enable stays high for the whole of a write, so the plain minimum write pulse is enough. The data driver is enabled through a separate pin for the pad logic outside the block.

Top module: `asram_port_ctrl`

## Requirements
- R1: During and right after reset, CS1 is high, CS2 is low, OE and WE are high, the data driver is off, and `host_busy` is low.
- R2: A read returns the byte last written to that address. `host_ready` goes high SETUP_CYC + READ_CYC clock edges after the edge that accepts the request, and `host_rdata` holds the byte at that time.
- R3: A write stores `host_wdata` at `host_addr`. `host_ready` goes high SETUP_CYC + WPULSE_CYC + WHOLD_CYC edges after the accepting edge.
- R4: The two chip selects always move together: CS1 is low exactly when CS2 is high. Both are inactive while the sequencer is idle.
- R5: `mem_addr` does not change while the memory is selected. WE is low only while the memory is selected.
- R6: OE is high whenever WE is low or the data driver is on. The data driver is on only while the memory is selected.
- R7: Every WE low pulse lasts at least WPULSE_CYC clock cycles.
- R8: After WE returns high, the select and the data driver stay on with unchanged data for at least WHOLD_CYC cycles.
- R9: After OE returns high, the data driver stays off for at least TURN_CYC cycles.
- R10: A request raised while `host_busy` is high is ignored: it produces no memory access and no extra `host_ready`. `host_ready` lasts exactly one cycle.
- R11: Read data is sampled only after OE has been low with the memory selected and the address stable for READ_CYC cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_req | input | 1 | Request strobe, taken only while not busy |
| host_write | input | 1 | 1 = write, 0 = read |
| host_addr | input | 13 | Word address |
| host_wdata | input | 8 | Byte to write |
| host_busy | output | 1 | An access is in progress |
| host_ready | output | 1 | One-cycle completion pulse |
| host_rdata | output | 8 | Byte captured by the last read |
| mem_addr | output | 13 | Memory address lines |
| mem_cs1_n | output | 1 | Active-low chip select |
| mem_cs2 | output | 1 | Active-high chip select |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_dout | output | 8 | Data toward the memory |
| mem_dout_en | output | 1 | Drive enable for the shared data bus |
| mem_din | input | 8 | Data from the memory |

## Verification
The checker checks the pin rules on every cycle. These are the paired selects, the address frozen while selected, OE kept high during writes and while the bus is driven, the minimum WE pulse counted with a run counter, the hold after WE rises, the turnaround gap after OE, and the one-cycle ready pulse. Only the bench's scenarios can show that the data itself is right. The bench models the memory: it returns a wrong byte until the read window has lasted long enough, and it latches data when the write window closes. It also measures the ready latency and shows that a request issued while busy leaves the memory untouched.

// File: rtl/asram_pkg.sv
// Shared types and helpers for the asynchronous SRAM access sequencer.
// Assumes nothing beyond IEEE 1800-2017 elaboration-time functions.
package asram_pkg;

    // Access phases; each timed phase is closed by the phase timer.
    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_ADDR  = 3'd1,
        PH_READ  = 3'd2,
        PH_WRITE = 3'd3,
        PH_WHOLD = 3'd4,
        PH_TURN  = 3'd5
    } phase_e;

    // Forces a cycle count to at least one cycle.
    function automatic int unsigned at_least_one(input int unsigned v);
        return (v < 1) ? 1 : v;
    endfunction

    // Larger of two counts.
    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/asram_phase_timer.sv
// Down-counter that times one access phase.
// Loading value N makes done rise N cycles later; done is high while the count is zero.
// Assumes load is pulsed only on a phase change.
module asram_phase_timer #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);

    logic [CNT_W-1:0] cnt_q;

    // Load on a phase change, otherwise count down to zero and stop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);

endmodule

// File: rtl/asram_seq.sv
// Phase sequencer: idle -> address setup -> read or write window -> turnaround or hold -> idle.
// Produces the next phase (the pin stage registers strobes from it), the timer loads,
// the read-capture strobe and the completion pulse request.
// Assumes every cycle parameter is at least one; smaller values are raised to one.
module asram_seq
    import asram_pkg::*;
#(
    parameter int CNT_W      = 2,
    parameter int SETUP_CYC  = 1,
    parameter int READ_CYC   = 2,
    parameter int WPULSE_CYC = 2,
    parameter int WHOLD_CYC  = 1,
    parameter int TURN_CYC   = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             op_write,
    input  logic             tmr_done,
    output phase_e           phase,
    output phase_e           nxt_phase,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output logic             capture,
    output logic             ready_set
);

    localparam logic [CNT_W-1:0] L_SETUP = CNT_W'(at_least_one(SETUP_CYC) - 1);
    localparam logic [CNT_W-1:0] L_READ  = CNT_W'(at_least_one(READ_CYC) - 1);
    localparam logic [CNT_W-1:0] L_WP    = CNT_W'(at_least_one(WPULSE_CYC) - 1);
    localparam logic [CNT_W-1:0] L_HOLD  = CNT_W'(at_least_one(WHOLD_CYC) - 1);
    localparam logic [CNT_W-1:0] L_TURN  = CNT_W'(at_least_one(TURN_CYC) - 1);

    phase_e phase_q;

    // Next-phase decision and timer reload at each phase boundary.
    always_comb begin
        nxt_phase = phase_q;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        capture   = 1'b0;
        ready_set = 1'b0;
        unique case (phase_q)
            PH_IDLE: begin
                if (start) begin
                    nxt_phase = PH_ADDR;
                    tmr_load  = 1'b1;
                    tmr_val   = L_SETUP;
                end
            end
            PH_ADDR: begin
                if (tmr_done) begin
                    nxt_phase = op_write ? PH_WRITE : PH_READ;
                    tmr_load  = 1'b1;
                    tmr_val   = op_write ? L_WP : L_READ;
                end
            end
            PH_READ: begin
                if (tmr_done) begin
                    capture   = 1'b1;
                    ready_set = 1'b1;
                    nxt_phase = PH_TURN;
                    tmr_load  = 1'b1;
                    tmr_val   = L_TURN;
                end
            end
            PH_WRITE: begin
                if (tmr_done) begin
                    nxt_phase = PH_WHOLD;
                    tmr_load  = 1'b1;
                    tmr_val   = L_HOLD;
                end
            end
            PH_WHOLD: begin
                if (tmr_done) begin
                    ready_set = 1'b1;
                    nxt_phase = PH_IDLE;
                end
            end
            PH_TURN: begin
                if (tmr_done) begin
                    nxt_phase = PH_IDLE;
                end
            end
            default: nxt_phase = PH_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
        end else begin
            phase_q <= nxt_phase;
        end
    end

    assign phase = phase_q;

endmodule

// File: rtl/asram_pins.sv
// Registered memory strobes, decoded from the phase the sequencer enters next,
// so each strobe changes on a clock edge with no combinational glitch.
// Assumes the address and write data are held by the caller while a window is open.
module asram_pins
    import asram_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  phase_e nxt_phase,
    output logic   cs1_n,
    output logic   cs2,
    output logic   oe_n,
    output logic   we_n,
    output logic   dout_en
);

    logic sel_nxt;
    logic drive_nxt;

    // Which upcoming phases keep the memory selected or the bus driven.
    always_comb begin
        sel_nxt   = (nxt_phase == PH_READ) || (nxt_phase == PH_WRITE) || (nxt_phase == PH_WHOLD);
        drive_nxt = (nxt_phase == PH_WRITE) || (nxt_phase == PH_WHOLD);
    end

    // Strobe registers; reset leaves the memory deselected and the bus undriven.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs1_n   <= 1'b1;
            cs2     <= 1'b0;
            oe_n    <= 1'b1;
            we_n    <= 1'b1;
            dout_en <= 1'b0;
        end else begin
            cs1_n   <= !sel_nxt;
            cs2     <= sel_nxt;
            oe_n    <= !(nxt_phase == PH_READ);
            we_n    <= !(nxt_phase == PH_WRITE);
            dout_en <= drive_nxt;
        end
    end

endmodule

// File: rtl/asram_port_ctrl.sv
// Top of the asynchronous SRAM access sequencer.
// Takes one host request at a time, holds its address and data, and runs the
// phase sequencer, phase timer and strobe registers. Assumes the host watches
// host_busy and that the memory's timings were converted to whole clock cycles.
module asram_port_ctrl
    import asram_pkg::*;
#(
    parameter int ADDR_W     = 13,
    parameter int DATA_W     = 8,
    parameter int SETUP_CYC  = 1,
    parameter int READ_CYC   = 2,
    parameter int WPULSE_CYC = 2,
    parameter int WHOLD_CYC  = 1,
    parameter int TURN_CYC   = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_req,
    input  logic              host_write,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic              host_busy,
    output logic              host_ready,
    output logic [DATA_W-1:0] host_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cs1_n,
    output logic              mem_cs2,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [DATA_W-1:0] mem_dout,
    output logic              mem_dout_en,
    input  logic [DATA_W-1:0] mem_din
);

    localparam int MAX_CYC = max2(max2(max2(SETUP_CYC, READ_CYC), max2(WPULSE_CYC, WHOLD_CYC)), TURN_CYC);
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    phase_e           phase;
    phase_e           nxt_phase;
    logic             accept;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_done;
    logic             capture;
    logic             ready_set;

    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic              write_q;
    logic [DATA_W-1:0] rdata_q;
    logic              ready_q;

    assign accept = host_req && (phase == PH_IDLE);

    // Hold the accepted request for the whole access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            write_q <= 1'b0;
        end else if (accept) begin
            addr_q  <= host_addr;
            wdata_q <= host_wdata;
            write_q <= host_write;
        end
    end

    // Capture read data at the close of the read window and flag completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
            ready_q <= 1'b0;
        end else begin
            ready_q <= ready_set;
            if (capture) begin
                rdata_q <= mem_din;
            end
        end
    end

    asram_seq #(
        .CNT_W     (CNT_W),
        .SETUP_CYC (SETUP_CYC),
        .READ_CYC  (READ_CYC),
        .WPULSE_CYC(WPULSE_CYC),
        .WHOLD_CYC (WHOLD_CYC),
        .TURN_CYC  (TURN_CYC)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (accept),
        .op_write (write_q),
        .tmr_done (tmr_done),
        .phase    (phase),
        .nxt_phase(nxt_phase),
        .tmr_load (tmr_load),
        .tmr_val  (tmr_val),
        .capture  (capture),
        .ready_set(ready_set)
    );

    asram_phase_timer #(
        .CNT_W(CNT_W)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .load_val(tmr_val),
        .done    (tmr_done)
    );

    asram_pins u_pins (
        .clk      (clk),
        .rst_n    (rst_n),
        .nxt_phase(nxt_phase),
        .cs1_n    (mem_cs1_n),
        .cs2      (mem_cs2),
        .oe_n     (mem_oe_n),
        .we_n     (mem_we_n),
        .dout_en  (mem_dout_en)
    );

    assign host_busy  = (phase != PH_IDLE);
    assign host_ready = ready_q;
    assign host_rdata = rdata_q;
    assign mem_addr   = addr_q;
    assign mem_dout   = wdata_q;

endmodule

// File: rtl/asram_port_ctrl_chk.sv
// Pin-protocol checker for asram_port_ctrl, attached with bind.
// Counts WE-low runs and OE-high gaps so that long windows need no deep $past.
module asram_port_ctrl_chk #(
    parameter int ADDR_W     = 13,
    parameter int DATA_W     = 8,
    parameter int WPULSE_CYC = 2,
    parameter int TURN_CYC   = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_busy,
    input logic              host_ready,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_cs1_n,
    input logic              mem_cs2,
    input logic              mem_oe_n,
    input logic              mem_we_n,
    input logic [DATA_W-1:0] mem_dout,
    input logic              mem_dout_en
);

    localparam int RUN_W = $clog2(WPULSE_CYC + 2) + 1;
    localparam int GAP_W = $clog2(TURN_CYC + 2) + 1;
    localparam logic [RUN_W-1:0] RUN_MAX = {RUN_W{1'b1}};
    localparam logic [GAP_W-1:0] GAP_MAX = {GAP_W{1'b1}};

    logic             sel;
    logic [RUN_W-1:0] we_run;
    logic [GAP_W-1:0] oe_gap;

    assign sel = !mem_cs1_n && mem_cs2;

    // Length of the current WE-low run, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_run <= '0;
        end else if (!mem_we_n) begin
            we_run <= (we_run == RUN_MAX) ? we_run : we_run + 1'b1;
        end else begin
            we_run <= '0;
        end
    end

    // Cycles since OE was last low, saturating; starts saturated.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oe_gap <= GAP_MAX;
        end else if (!mem_oe_n) begin
            oe_gap <= '0;
        end else begin
            oe_gap <= (oe_gap == GAP_MAX) ? oe_gap : oe_gap + 1'b1;
        end
    end

    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (mem_cs1_n && !mem_cs2 && mem_oe_n && mem_we_n && !mem_dout_en && !host_busy));

    assert_sel_pair_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_cs1_n == !mem_cs2);

    assert_idle_deselect_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !host_busy |-> !sel);

    assert_addr_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && $past(sel)) |-> $stable(mem_addr));

    assert_we_in_sel_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> sel);

    assert_oe_off_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we_n || mem_dout_en) |-> mem_oe_n);

    assert_drive_in_sel_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dout_en |-> sel);

    assert_wpulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (we_run >= RUN_W'(WPULSE_CYC)));

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (sel && mem_dout_en && $stable(mem_dout)));

    assert_turn_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dout_en |-> (oe_gap >= GAP_W'(TURN_CYC)));

    assert_ready_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        host_ready |=> !host_ready);

endmodule

bind asram_port_ctrl asram_port_ctrl_chk #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .WPULSE_CYC(WPULSE_CYC),
    .TURN_CYC  (TURN_CYC)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_busy  (host_busy),
    .host_ready (host_ready),
    .mem_addr   (mem_addr),
    .mem_cs1_n  (mem_cs1_n),
    .mem_cs2    (mem_cs2),
    .mem_oe_n   (mem_oe_n),
    .mem_we_n   (mem_we_n),
    .mem_dout   (mem_dout),
    .mem_dout_en(mem_dout_en)
);

// File: tb/asram_port_ctrl_test.sv
// Bench for asram_port_ctrl: a timing-aware memory model plus random and directed accesses.
module asram_port_ctrl_test;

    localparam int AW    = 13;
    localparam int DW    = 8;
    localparam int SETUP = 1;
    localparam int RDC   = 2;
    localparam int WPC   = 2;
    localparam int HOLD  = 1;
    localparam int TURN  = 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          host_req = 1'b0;
    logic          host_write = 1'b0;
    logic [AW-1:0] host_addr = '0;
    logic [DW-1:0] host_wdata = '0;
    logic          host_busy;
    logic          host_ready;
    logic [DW-1:0] host_rdata;
    logic [AW-1:0] mem_addr;
    logic          mem_cs1_n;
    logic          mem_cs2;
    logic          mem_oe_n;
    logic          mem_we_n;
    logic [DW-1:0] mem_dout;
    logic          mem_dout_en;
    logic [DW-1:0] mem_din = '0;

    int n_checks = 0;
    int n_fails  = 0;

    always #5 clk = ~clk;

    asram_port_ctrl #(
        .ADDR_W(AW), .DATA_W(DW), .SETUP_CYC(SETUP), .READ_CYC(RDC),
        .WPULSE_CYC(WPC), .WHOLD_CYC(HOLD), .TURN_CYC(TURN)
    ) uut (
        .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_write(host_write),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_busy(host_busy),
        .host_ready(host_ready), .host_rdata(host_rdata), .mem_addr(mem_addr),
        .mem_cs1_n(mem_cs1_n), .mem_cs2(mem_cs2), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n), .mem_dout(mem_dout), .mem_dout_en(mem_dout_en),
        .mem_din(mem_din)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [DW-1:0] init_val(input logic [AW-1:0] a);
        return a[7:0] ^ {3'b000, a[12:8]} ^ 8'h5A;
    endfunction

    function automatic int read_latency();
        return SETUP + RDC + 1;
    endfunction

    function automatic int write_latency();
        return SETUP + WPC + HOLD + 1;
    endfunction

    // Memory model contents and the bench's own expectation, kept apart.
    logic [DW-1:0] model_mem [int];
    logic [DW-1:0] exp_mem [int];

    function automatic logic [DW-1:0] model_rd(input logic [AW-1:0] a);
        return model_mem.exists(int'(a)) ? model_mem[int'(a)] : init_val(a);
    endfunction

    function automatic logic [DW-1:0] exp_rd(input logic [AW-1:0] a);
        return exp_mem.exists(int'(a)) ? exp_mem[int'(a)] : init_val(a);
    endfunction

    // Memory model: evaluated at the falling edge, away from the design's edge.
    logic [AW-1:0] prev_addr = '0;
    bit            prev_act  = 0;
    bit            prev_rd   = 0;
    int            rd_cnt    = 0;
    int            we_cnt    = 0;
    int            hold_cnt  = 0;
    bit            in_hold   = 0;
    logic [DW-1:0] wr_data   = '0;
    logic [DW-1:0] hold_data = '0;
    int            oe_gap    = 1000;
    bit            prev_drv  = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            bit sel;
            bit rd_now;
            sel = !mem_cs1_n && mem_cs2;
            // R5: address frozen while selected or writing
            if (prev_act && (sel || !mem_we_n))
                check(mem_addr == prev_addr, "R5 address moved in window", mem_addr, prev_addr);
            // R11: data is valid only after a full read window
            rd_now = sel && !mem_oe_n && mem_we_n;
            if (rd_now) begin
                rd_cnt  = (prev_rd && mem_addr == prev_addr) ? rd_cnt + 1 : 1;
                mem_din = (rd_cnt >= RDC) ? model_rd(mem_addr) : ~model_rd(mem_addr);
            end else begin
                rd_cnt  = 0;
                mem_din = 8'h00;
            end
            // R6/R7: write window, data latched when it closes
            if (sel && !mem_we_n) begin
                if (we_cnt == 0)
                    check(mem_dout_en && mem_oe_n, "R6 drive/OE at write start", {mem_dout_en, mem_oe_n}, 2'b11);
                we_cnt++;
                wr_data = mem_dout;
            end else if (we_cnt != 0) begin
                check(we_cnt >= WPC, "R7 write pulse width", we_cnt, WPC);
                model_mem[int'(prev_addr)] = wr_data;
                we_cnt    = 0;
                hold_cnt  = 0;
                hold_data = wr_data;
                in_hold   = 1;
            end
            // R8: select and data kept after the write window
            if (in_hold) begin
                if (sel && mem_dout_en) begin
                    hold_cnt++;
                    check(mem_dout == hold_data, "R8 data during hold", mem_dout, hold_data);
                end else begin
                    check(hold_cnt >= HOLD, "R8 hold length", hold_cnt, HOLD);
                    in_hold = 0;
                end
            end
            // R9: bus turnaround after output enable
            if (!mem_oe_n) oe_gap = 0;
            else if (oe_gap < 1000) oe_gap++;
            if (mem_dout_en && !prev_drv)
                check(oe_gap - 1 >= TURN, "R9 turnaround", oe_gap - 1, TURN);
            if (mem_dout_en)
                check(sel && mem_oe_n, "R6 drive only when selected, OE high", {sel, mem_oe_n}, 2'b11);
            prev_drv  = mem_dout_en;
            prev_act  = sel || !mem_we_n;
            prev_rd   = rd_now;
            prev_addr = mem_addr;
        end
    end

    // One access: issue at a falling edge once idle, then time the ready pulse.
    task automatic do_op(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
        int lat;
        while (host_busy) @(negedge clk);
        host_req   = 1'b1;
        host_write = wr;
        host_addr  = a;
        host_wdata = d;
        @(negedge clk);
        host_req = 1'b0;
        lat = 1;
        while (!host_ready && lat < 50) begin
            @(negedge clk);
            lat++;
        end
        if (wr) begin
            check(lat == write_latency(), "R3 write latency", lat, write_latency());
            exp_mem[int'(a)] = d;
        end else begin
            check(lat == read_latency(), "R2 read latency", lat, read_latency());
            check(host_rdata == exp_rd(a), "R2 read data", host_rdata, exp_rd(a));
        end
        @(negedge clk);
        check(!host_ready, "R10 ready one cycle", host_ready, 0);
    endtask

    function automatic logic [AW-1:0] pick_addr(input logic [AW-1:0] pool [16]);
        int r;
        r = int'($urandom_range(0, 19));
        if (r == 16) return '0;
        if (r >= 17) return {AW{1'b1}};
        return pool[r];
    endfunction

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        logic [AW-1:0] pool [16];
        int readies;
        void'($urandom(32'h5EED_0164));
        foreach (pool[i]) pool[i] = AW'($urandom_range(1, 8190));

        repeat (4) @(negedge clk);
        // R1: state held in reset
        check(mem_cs1_n && !mem_cs2 && mem_oe_n && mem_we_n && !mem_dout_en,
              "R1 pins in reset", {mem_cs1_n, mem_cs2, mem_oe_n, mem_we_n, mem_dout_en}, 5'b10110);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(mem_cs1_n && !mem_cs2 && mem_oe_n && mem_we_n && !mem_dout_en && !host_busy,
              "R1 pins after reset", {mem_cs1_n, mem_cs2, mem_oe_n, mem_we_n, mem_dout_en, host_busy}, 6'b101100);

        // Directed corners: lowest and highest address, unwritten read, read then write
        do_op(1'b0, 13'h0000, 8'h00);
        do_op(1'b1, 13'h0000, 8'hC3);
        do_op(1'b1, 13'h1FFF, 8'h3C);
        do_op(1'b0, 13'h1FFF, 8'h00);
        do_op(1'b0, 13'h0000, 8'h00);
        do_op(1'b1, 13'h0ABC, 8'hFF);
        do_op(1'b0, 13'h0ABC, 8'h00);

        // R4: idle pins deselected between accesses
        while (host_busy) @(negedge clk);
        check(mem_cs1_n && !mem_cs2, "R4 idle deselect", {mem_cs1_n, mem_cs2}, 2'b10);

        // R10: a request issued while busy is ignored
        host_req = 1'b1; host_write = 1'b1; host_addr = 13'h0123; host_wdata = 8'h11;
        @(negedge clk);
        host_req = 1'b0;
        @(negedge clk);
        check(host_busy, "R10 busy during access", host_busy, 1);
        host_req = 1'b1; host_write = 1'b1; host_addr = 13'h0456; host_wdata = 8'h99;
        @(negedge clk);
        host_req = 1'b0;
        exp_mem[32'h0123] = 8'h11;
        readies = 0;
        repeat (15) begin
            if (host_ready) readies++;
            @(negedge clk);
        end
        check(readies == 1, "R10 single ready", readies, 1);
        do_op(1'b0, 13'h0456, 8'h00);
        do_op(1'b0, 13'h0123, 8'h00);

        // Constrained random mix
        for (int k = 0; k < 400; k++) begin
            logic [AW-1:0] a;
            a = pick_addr(pool);
            do_op($urandom_range(0, 1) == 1, a, DW'($urandom));
        end

        repeat (5) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule